// File: doc/BRIEF.md
# Counter-Ramp Conversion Sequencer

This block is the digital half of a staircase analog-to-digital converter. It runs a free counter whose value goes straight out as the code for an external DAC. Each clock moves the code up by one LSB, so every step of the staircase has the same height. An external comparator reports whether the DAC level is still under the analog input (high) or has gone past it (low).

The comparator arrives asynchronously, so it passes through a synchronizer first. The block keeps a short history of recent codes, as deep as the synchronizer, so that each synchronized comparator sample is judged against the code that produced it. The first code judged to be above the input is written into a parallel result register. A one-cycle valid strobe marks that write, and the counter restarts from zero on the same edge. If the ramp reaches full scale without a trip, the counter wraps to zero, giving a sawtooth. In that case the result is loaded with all ones, an overflow flag is raised and the strobe pulses.

After a capture, the sequencer accepts no further trip until the comparator has been seen high again. A comparator that stays low therefore cannot produce a stream of captures at low codes.

Top module: `ramp_adc_seq`

## Requirements
- R1: `dac_code` always shows the ramp counter. From one cycle to the next it rises by exactly one, wrapping 255 to 0, except on the edge that reloads it to zero after a trip capture.
- R2: With a comparator that reads high (DAC below input) for codes up to a threshold T and low above it, T from 0 to 254, each conversion stores T+1 in `result`. `res_valid` is high for that single cycle and `overflow` is 0.
- R3: In the cycle where `res_valid` marks a trip capture, `dac_code` is 0. After a trip capture with threshold T below 255, the next capture comes exactly T+4 cycles later (two cycles of synchronizer delay, one cycle of capture register, plus T+1 ramp steps).
- R4: In every cycle where `res_valid` is low, `result` and `overflow` keep their previous values.
- R5: If full scale (255) is judged below the input, the counter wraps without a reload. On that edge `result` becomes 8'hFF, `overflow` becomes 1 and `res_valid` pulses. With the comparator always high, the captures repeat every 256 cycles. When full scale follows a trip capture, the overflow capture comes 258 cycles after it.
- R6: The next trip capture after an overflow clears `overflow` to 0 in the same cycle as its strobe.
- R7: While the comparator is held low after a capture, `res_valid` stays low. Once the comparator returns to the threshold behaviour, the next capture again stores T+1.
- R8: While `rst` is high, `dac_code`, `result`, `res_valid` and `overflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_in | input | 1 | Asynchronous comparator: 1 = DAC below input, 0 = DAC above input |
| dac_code | output | 8 | Code driven to the external DAC (current counter value) |
| result | output | 8 | Last captured conversion result |
| res_valid | output | 1 | One-cycle strobe in the cycle `result` is updated |
| overflow | output | 1 | 1 when the last capture was a full-scale wrap |

## Verification
The bench aims at the synchronizer latency. A design that captured the live counter instead of the delay-matched history would report T+3, and the exact T+4 conversion spacing shows whether the reload lands on the right edge. The extreme thresholds come next: T=0 and T=1 check that the ramp is re-armed quickly enough after a reload. T=254 checks that a trip at code 255 is a normal capture and not an overflow. T=255 checks the all-ones result, the flag, and the 256- and 258-cycle spacing. A long hold of the comparator low catches a design that does not wait for the comparator to rise again. That design would strobe on every wrap or at code zero. Randomized thresholds, some right after an overflow, check that the flag is cleared again.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;

    // Decision taken on one synchronized comparator sample.
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_TRIP = 2'd1,
        EV_WRAP = 2'd2
    } judge_ev_e;

    // Comparator level meaning "DAC still below the input".
    localparam logic CMP_BELOW = 1'b1;

    // Code paired with the comparator sample that judged it.
    typedef struct packed {
        logic       below;
        logic [7:0] code;
    } judged_pair_t;

endpackage

// File: rtl/ramp_sync.sv
module ramp_sync
    import ramp_adc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{CMP_BELOW}};
        end else begin
            chain[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/ramp_counter.sv
module ramp_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         reload,
    output logic [W-1:0] code
);
    always_ff @(posedge clk) begin
        if (rst || reload) begin
            code <= '0;
        end else begin
            code <= code + 1'b1;
        end
    end
endmodule

// File: rtl/ramp_judge.sv
module ramp_judge
    import ramp_adc_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] code,
    input  logic         cmp_sync,
    output judge_ev_e    ev,
    output logic [W-1:0] judged_code
);
    localparam logic [W-1:0] FULL = '1;

    logic [W-1:0] hist [DEPTH];
    logic         armed;

    // Delay line matching the synchronizer latency.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                hist[i] <= '0;
            end
        end else begin
            hist[0] <= code;
            for (int i = 1; i < DEPTH; i++) begin
                hist[i] <= hist[i-1];
            end
        end
    end

    assign judged_code = hist[DEPTH-1];

    always_comb begin
        ev = EV_NONE;
        if (armed) begin
            if (cmp_sync != CMP_BELOW) begin
                ev = EV_TRIP;
            end else if (judged_code == FULL) begin
                ev = EV_WRAP;
            end
        end
    end

    // Disarm on a trip; re-arm once the comparator is seen below again.
    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else if (ev == EV_TRIP) begin
            armed <= 1'b0;
        end else if (cmp_sync == CMP_BELOW) begin
            armed <= 1'b1;
        end
    end
endmodule

// File: rtl/ramp_result.sv
module ramp_result
    import ramp_adc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  judge_ev_e    ev,
    input  logic [W-1:0] judged_code,
    output logic [W-1:0] result,
    output logic         valid,
    output logic         ovf
);
    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            valid  <= 1'b0;
            ovf    <= 1'b0;
        end else begin
            valid <= 1'b0;
            case (ev)
                EV_TRIP: begin
                    result <= judged_code;
                    ovf    <= 1'b0;
                    valid  <= 1'b1;
                end
                EV_WRAP: begin
                    result <= '1;
                    ovf    <= 1'b1;
                    valid  <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ramp_adc_seq.sv
module ramp_adc_seq
    import ramp_adc_pkg::*;
#(
    parameter int CODE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_in,
    output logic [CODE_W-1:0] dac_code,
    output logic [CODE_W-1:0] result,
    output logic              res_valid,
    output logic              overflow
);
    logic              cmp_sync;
    judge_ev_e         ev;
    logic [CODE_W-1:0] judged_code;
    logic              reload;

    ramp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (cmp_in),
        .dout (cmp_sync)
    );

    assign reload = (ev == EV_TRIP);

    ramp_counter #(.W(CODE_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .reload (reload),
        .code   (dac_code)
    );

    ramp_judge #(.W(CODE_W), .DEPTH(SYNC_STAGES)) u_judge (
        .clk         (clk),
        .rst         (rst),
        .code        (dac_code),
        .cmp_sync    (cmp_sync),
        .ev          (ev),
        .judged_code (judged_code)
    );

    ramp_result #(.W(CODE_W)) u_res (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .judged_code (judged_code),
        .result      (result),
        .valid       (res_valid),
        .ovf         (overflow)
    );
endmodule

// File: rtl/ramp_adc_chk.sv
module ramp_adc_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] dac_code,
    input logic [W-1:0] result,
    input logic         res_valid,
    input logic         overflow
);
    localparam logic [W-1:0] ONE = W'(1);

    // R1: unit step or reload to zero
    p_step_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((dac_code == $past(dac_code) + ONE) || (dac_code == '0)));

    // R3: a trip capture coincides with the reloaded ramp
    p_reload_r3: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !overflow) |-> (dac_code == '0));

    // R4: result and flag hold between strobes
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> ($stable(result) && $stable(overflow)));

    // R5: overflow capture stores full scale
    p_ovf_full_r5: assert property (@(posedge clk) disable iff (rst)
        (res_valid && overflow) |-> (result == '1));

    // R6: flag only drops together with a strobe
    p_ovf_clear_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(overflow) |-> res_valid);

    // R8: reset state
    p_reset_r8: assert property (@(posedge clk)
        rst |=> (dac_code == '0 && result == '0 && !res_valid && !overflow));
endmodule

bind ramp_adc_seq ramp_adc_chk #(.W(CODE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dac_code  (dac_code),
    .result    (result),
    .res_valid (res_valid),
    .overflow  (overflow)
);

// File: tb/ramp_adc_seq_bench.sv
module ramp_adc_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmp_in;
    logic [7:0] dac_code;
    logic [7:0] result;
    logic       res_valid;
    logic       overflow;

    int th = 10;
    bit force_low = 1'b0;
    int total = 0;
    int bad = 0;
    bit mon_en = 1'b0;

    // Behavioural DAC plus comparator: high while code <= threshold.
    assign cmp_in = force_low ? 1'b0 : (int'(dac_code) <= th);

    always #(CLK_PERIOD/2) clk = ~clk;

    ramp_adc_seq u_ramp_adc_seq (
        .clk       (clk),
        .rst       (rst),
        .cmp_in    (cmp_in),
        .dac_code  (dac_code),
        .result    (result),
        .res_valid (res_valid),
        .overflow  (overflow)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_gap(input int prev_kind, input int t);
        if (prev_kind == 0) return (t == 255) ? 258 : t + 4;
        if (prev_kind == 1 && t == 255) return 256;
        return -1;
    endfunction

    // Cycle monitor: R1 step, R4 hold.
    logic [7:0] prev_code;
    logic [7:0] prev_res;
    logic       prev_ovf;
    bit         have_prev = 1'b0;
    always @(negedge clk) begin
        if (mon_en) begin
            if (have_prev) begin
                if (!((dac_code == 8'(prev_code + 8'd1)) ||
                      (dac_code == 8'd0 && res_valid && !overflow)))
                    chk("R1 step", int'(dac_code), int'(8'(prev_code + 8'd1)));
                else
                    total++;
                if (!res_valid) begin
                    chk("R4 result hold", int'(result), int'(prev_res));
                    chk("R4 flag hold", int'(overflow), int'(prev_ovf));
                end
            end
            prev_code = dac_code;
            prev_res  = result;
            prev_ovf  = overflow;
            have_prev = 1'b1;
        end
    end

    task automatic do_conv(input int t, input int prev_kind, output int kind);
        int n;
        bit got;
        int g;
        bit exp_ovf;
        th = t;
        n = 0;
        got = 1'b0;
        while (!got && n < 3000) begin
            @(negedge clk);
            n++;
            if (res_valid) got = 1'b1;
        end
        if (!got) begin
            chk("R2 capture timeout", 0, 1);
            kind = 2;
        end else begin
            exp_ovf = (t == 255);
            if (exp_ovf) begin
                chk("R5 full-scale result", int'(result), 255);
                chk("R5 overflow flag", int'(overflow), 1);
            end else begin
                chk("R2 captured code", int'(result), t + 1);
                if (prev_kind == 1)
                    chk("R6 flag cleared", int'(overflow), 0);
                else
                    chk("R2 overflow low", int'(overflow), 0);
                chk("R3 code reloaded", int'(dac_code), 0);
            end
            g = exp_gap(prev_kind, t);
            if (g >= 0) begin
                if (exp_ovf) chk("R5 period", n, g);
                else         chk("R3 period", n, g);
            end
            kind = exp_ovf ? 1 : 0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int k;
        int t;
        int seen;
        void'($urandom(32'd4711));
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 reset dac_code", int'(dac_code), 0);
        chk("R8 reset result", int'(result), 0);
        chk("R8 reset valid", int'(res_valid), 0);
        chk("R8 reset overflow", int'(overflow), 0);
        rst = 1'b0;
        mon_en = 1'b1;

        do_conv(10, 2, k);
        do_conv(0, k, k);
        do_conv(1, k, k);
        do_conv(0, k, k);
        do_conv(254, k, k);
        do_conv(255, k, k);
        do_conv(255, k, k);
        do_conv(40, k, k);

        // R7: comparator held low after a capture
        force_low = 1'b1;
        seen = 0;
        for (int i = 0; i < 700; i++) begin
            @(negedge clk);
            if (res_valid) seen++;
        end
        chk("R7 no capture while held low", seen, 0);
        force_low = 1'b0;
        do_conv(40, 2, k);
        chk("R7 capture after release", int'(result), 41);

        for (int i = 0; i < 24; i++) begin
            t = 2 + int'($urandom_range(252));
            if ($urandom_range(7) == 0) t = 255;
            do_conv(t, k, k);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule